// File: doc/BRIEF.md
# Display Link Transmitter Control Register with Merged Interrupt

This block holds the 32-bit read/write control word of a serial display link transmitter and sends its fields to the datapath. The fields are the link rate code, the lane count, the framing mode and the training-pattern select. The lane count is decoded into a per-lane enable mask. When the count is not one of the defined codes, every lane is forced to a constant logical zero, which acts as a power-down stand-in for compliance testing.

The block also drives one registered level interrupt to the host processor. The interrupt merges two causes, and each cause has its own enable bit in the control word:

- **Auxiliary cause.** It is latched on a rising edge of the auxiliary channel's message-ready flag. A read of the auxiliary command register acknowledges it.
- **Hot-plug cause.** A non-zero hot-plug event code is latched. A read of the status register returns the code and clears it.

Clearing an enable bit masks its cause without acknowledging it.

Top module: `link_ctl_regs`

## Requirements
- R1: After reset the control word reads 0x00000000, and the interrupt, link rate, framing, training-pattern and lane-mask outputs are all zero.
- R2: A write at the control offset (0x00) is stored. Read data appears on `bus_rdata` in the cycle after the read strobe. Bits 29, 20, 18:10 and 4 always read as zero, so the writable mask is 0xDFE803EF.
- R3: One cycle after a control write, `link_rate` equals bits 28:21, `enh_framing` equals bit 19 (1 = enhanced) and `train_pat` equals bits 3:0.
- R4: The lane-count field is bits 9:5 and is stored as written. 00001 enables lane 0 only, 00010 enables lanes 0 to 1, and 00100 enables lanes 0 to 3. Any other value enables no lane and raises `lanes_zero`.
- R5: A rising edge of `aux_msg_ready` sets the auxiliary pending flag. With bit 30 set, `irq` is high one cycle after the flag is set.
- R6: A read at the auxiliary command offset (0x08) clears the auxiliary pending flag. Clearing bit 30 drops `irq` but keeps the flag, so setting bit 30 again raises `irq` again.
- R7: A non-zero `hpd_event` is latched as the hot-plug code. With bit 31 set, `irq` is high one cycle after the code becomes non-zero.
- R8: A read at the status offset (0x04) returns the hot-plug code in bits 1:0 and zero elsewhere, then clears the code. If a non-zero event arrives in the same cycle as the read, the new code is latched instead of being cleared.
- R9: `irq` is registered. It goes high or low exactly one cycle after the OR of the two enabled causes changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| aux_msg_ready | input | 1 | Auxiliary reply-ready flag (level) |
| hpd_event | input | 2 | Hot-plug event code, non-zero for one cycle on an event |
| link_rate | output | 8 | Link rate code, in multiples of 270 Mbps |
| enh_framing | output | 1 | Enhanced framing select |
| train_pat | output | 4 | Training-pattern select |
| lane_en | output | 4 | Per-lane enable mask |
| lanes_zero | output | 1 | All lanes forced to constant zero |
| irq | output | 1 | Merged level interrupt |

## Verification
The bench builds the block with its default parameters: four lanes, an 8-bit offset bus, and the control, status and auxiliary command offsets at 0x00, 0x04 and 0x08. With four lanes all three defined lane codes are legal, so the full decode can be tested, including the one-hot code that enables every lane and the illegal codes that force zero. The three distinct offsets let the bench issue each acknowledging read on its own. It can also place a status read in the same cycle as a fresh hot-plug event.

// File: rtl/lctl_pkg.sv
package lctl_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned RATE_W    = 8;
   localparam int unsigned LANE_W    = 5;
   localparam int unsigned PAT_W     = 4;
   localparam int unsigned EVT_W     = 2;
   localparam int unsigned HPD_IE_B  = 31;
   localparam int unsigned AUX_IE_B  = 30;
   localparam int unsigned RATE_LSB  = 21;
   localparam int unsigned FRAME_B   = 19;
   localparam int unsigned LANE_LSB  = 5;
   localparam int unsigned PAT_LSB   = 0;
   localparam logic [WORD_W-1:0] CTL_RW_MASK = 32'hDFE8_03EF;

   typedef struct packed {
      logic              hpd_ie;
      logic              aux_ie;
      logic [RATE_W-1:0] rate;
      logic              enh;
      logic [LANE_W-1:0] lanes;
      logic [PAT_W-1:0]  pat;
   } ctl_fields_t;

   function automatic ctl_fields_t split_ctl(input logic [WORD_W-1:0] w);
      ctl_fields_t f;
      f.hpd_ie = w[HPD_IE_B];
      f.aux_ie = w[AUX_IE_B];
      f.rate   = w[RATE_LSB +: RATE_W];
      f.enh    = w[FRAME_B];
      f.lanes  = w[LANE_LSB +: LANE_W];
      f.pat    = w[PAT_LSB +: PAT_W];
      return f;
   endfunction
endpackage

// File: rtl/lctl_word_reg.sv
module lctl_word_reg
   import lctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] word_q,
   output ctl_fields_t       fields
);
   always_ff @(posedge clk) begin
      if (!rst_n)     word_q <= '0;
      else if (wr_en) word_q <= wdata & CTL_RW_MASK;
   end

   assign fields = split_ctl(word_q);

   // R3: fields follow the written word one cycle later
   a_r3_rate_follows: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> fields.rate == $past(wdata[RATE_LSB +: RATE_W]));
   a_r3_pat_follows: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> fields.pat == $past(wdata[PAT_LSB +: PAT_W]));
endmodule

// File: rtl/lctl_lane_dec.sv
module lctl_lane_dec
   import lctl_pkg::*;
#(
   parameter int unsigned MAX_LANES = 4
)(
   input  logic [LANE_W-1:0]    code,
   output logic [MAX_LANES-1:0] lane_en,
   output logic                 all_zero
);
   localparam int unsigned ONE_LANE = 1;

   initial begin
      if (MAX_LANES != 1 && MAX_LANES != 2 && MAX_LANES != 4)
         $error("lctl_lane_dec: MAX_LANES must be 1, 2 or 4");
      if (MAX_LANES > (ONE_LANE << (LANE_W - 1)))
         $error("lctl_lane_dec: lane field too narrow");
   end

   logic [3:0] count;
   always_comb begin
      unique case (code)
         5'b00001: count = 4'd1;
         5'b00010: count = (MAX_LANES >= 2) ? 4'd2 : 4'd0;
         5'b00100: count = (MAX_LANES >= 4) ? 4'd4 : 4'd0;
         default:  count = 4'd0;
      endcase
   end

   for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
      assign lane_en[i] = (count > 4'(i));
   end

   assign all_zero = (count == 4'd0);

   // R4: the enable mask is always a contiguous run starting at lane 0
   always_comb begin
      a_r4_mask_contig: assert (((lane_en + 1'b1) & lane_en) == '0);
   end
endmodule

// File: rtl/lctl_irq.sv
module lctl_irq
   import lctl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             aux_ie,
   input  logic             hpd_ie,
   input  logic             aux_ready,
   input  logic             aux_ack,
   input  logic [EVT_W-1:0] hpd_in,
   input  logic             hpd_ack,
   output logic [EVT_W-1:0] hpd_code,
   output logic             irq
);
   logic ready_d, aux_pend;
   logic aux_rise, cause;

   assign aux_rise = aux_ready & ~ready_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_d  <= 1'b0;
         aux_pend <= 1'b0;
         hpd_code <= '0;
         irq      <= 1'b0;
      end else begin
         ready_d <= aux_ready;
         if (aux_rise)     aux_pend <= 1'b1;
         else if (aux_ack) aux_pend <= 1'b0;
         if (hpd_in != '0) hpd_code <= hpd_in;
         else if (hpd_ack) hpd_code <= '0;
         irq <= cause;
      end
   end

   assign cause = (aux_ie & aux_pend) | (hpd_ie & (hpd_code != '0));

   a_r5_aux_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_ie && aux_pend) |=> irq);
   a_r6_aux_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (aux_ack && !aux_rise) |=> !aux_pend);
   a_r7_hpd_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (hpd_ie && hpd_code != '0) |=> irq);
   a_r8_hpd_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (hpd_ack && hpd_in == '0) |=> hpd_code == '0);
   a_r8_new_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hpd_in != '0) |=> hpd_code == $past(hpd_in));
   a_r9_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !((aux_ie && aux_pend) || (hpd_ie && hpd_code != '0)) |=> !irq);
endmodule

// File: rtl/link_ctl_regs.sv
module link_ctl_regs
   import lctl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned MAX_LANES   = 4,
   parameter logic [7:0]  CTL_OFS     = 8'h00,
   parameter logic [7:0]  STAT_OFS    = 8'h04,
   parameter logic [7:0]  AUXCMD_OFS  = 8'h08
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [WORD_W-1:0]    bus_wdata,
   output logic [WORD_W-1:0]    bus_rdata,
   input  logic                 aux_msg_ready,
   input  logic [EVT_W-1:0]     hpd_event,
   output logic [RATE_W-1:0]    link_rate,
   output logic                 enh_framing,
   output logic [PAT_W-1:0]     train_pat,
   output logic [MAX_LANES-1:0] lane_en,
   output logic                 lanes_zero,
   output logic                 irq
);
   initial begin
      if (ADDR_W < 4 || ADDR_W > 8)
         $error("link_ctl_regs: ADDR_W must be 4..8");
      if (CTL_OFS == STAT_OFS || CTL_OFS == AUXCMD_OFS || STAT_OFS == AUXCMD_OFS)
         $error("link_ctl_regs: register offsets must differ");
   end

   logic hit_ctl, hit_stat, hit_aux;
   assign hit_ctl  = (bus_addr == CTL_OFS[ADDR_W-1:0]);
   assign hit_stat = (bus_addr == STAT_OFS[ADDR_W-1:0]);
   assign hit_aux  = (bus_addr == AUXCMD_OFS[ADDR_W-1:0]);

   logic [WORD_W-1:0] word_q;
   ctl_fields_t       f;
   logic [EVT_W-1:0]  hpd_code;

   lctl_word_reg u_word (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr & hit_ctl),
      .wdata(bus_wdata), .word_q(word_q), .fields(f)
   );

   lctl_lane_dec #(.MAX_LANES(MAX_LANES)) u_lanes (
      .code(f.lanes), .lane_en(lane_en), .all_zero(lanes_zero)
   );

   lctl_irq u_irq (
      .clk(clk), .rst_n(rst_n), .aux_ie(f.aux_ie), .hpd_ie(f.hpd_ie),
      .aux_ready(aux_msg_ready), .aux_ack(bus_rd & hit_aux),
      .hpd_in(hpd_event), .hpd_ack(bus_rd & hit_stat),
      .hpd_code(hpd_code), .irq(irq)
   );

   assign link_rate   = f.rate;
   assign enh_framing = f.enh;
   assign train_pat   = f.pat;

   always_ff @(posedge clk) begin
      if (!rst_n)       bus_rdata <= '0;
      else if (bus_rd) begin
         if (hit_ctl)       bus_rdata <= word_q;
         else if (hit_stat) bus_rdata <= {{(WORD_W-EVT_W){1'b0}}, hpd_code};
         else               bus_rdata <= '0;
      end else            bus_rdata <= '0;
   end

   // R2: reserved control bits never appear on a control read
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit_ctl) |=> (bus_rdata & ~CTL_RW_MASK) == '0);
endmodule

// File: tb/sim_link_ctl_regs.sv
module sim_link_ctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        aux_msg_ready = 1'b0;
   logic [1:0]  hpd_event = '0;
   logic [7:0]  link_rate;
   logic        enh_framing;
   logic [3:0]  train_pat;
   logic [3:0]  lane_en;
   logic        lanes_zero;
   logic        irq;
   int          errors = 0, checks = 0;

   always #5 clk = ~clk;

   link_ctl_regs u0 (.*);

   localparam int NV = 7;
   localparam logic [31:0] V_WR [0:NV-1] = '{32'hFFFF_FFFF, 32'h00C0_0021, 32'h0148_0042,
      32'h0280_0087, 32'h03D0_109B, 32'h0000_0060, 32'h0000_000C};
   localparam logic [31:0] V_RB [0:NV-1] = '{32'hDFE8_03EF, 32'h00C0_0021, 32'h0148_0042,
      32'h0280_0087, 32'h03C0_008B, 32'h0000_0060, 32'h0000_000C};
   localparam logic [3:0] V_MASK [0:NV-1] = '{4'b0000, 4'b0001, 4'b0011, 4'b1111,
      4'b1111, 4'b0000, 4'b0000};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      tick();
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(8'h00, d);
      chk("R1 ctl", d, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 outs", {15'b0, link_rate, enh_framing, train_pat, lane_en}, 32'h0);

      // vector walk: R2 readback, R3 fields, R4 lane decode
      for (int i = 0; i < NV; i++) begin
         wr(8'h00, V_WR[i]);
         chk("R3 rate", {24'b0, link_rate}, {24'b0, V_RB[i][28:21]});
         chk("R3 frame", {31'b0, enh_framing}, {31'b0, V_RB[i][19]});
         chk("R3 pat", {28'b0, train_pat}, {28'b0, V_RB[i][3:0]});
         chk("R4 mask", {28'b0, lane_en}, {28'b0, V_MASK[i]});
         chk("R4 zero", {31'b0, lanes_zero}, {31'b0, (V_MASK[i] == 4'b0)});
         rd(8'h00, d);
         chk("R2 readback", d, V_RB[i]);
      end

      // R5 auxiliary cause
      wr(8'h00, 32'h4000_0000);
      aux_msg_ready = 1'b1;
      tick();
      chk("R9 aux lag", {31'b0, irq}, 32'h0);
      tick();
      chk("R5 aux irq", {31'b0, irq}, 32'h1);
      // R6 acknowledge by command read
      rd(8'h08, d);
      chk("R9 hold after ack", {31'b0, irq}, 32'h1);
      tick();
      chk("R6 ack drops", {31'b0, irq}, 32'h0);
      tick();
      chk("R5 level no retrigger", {31'b0, irq}, 32'h0);
      aux_msg_ready = 1'b0; tick();
      aux_msg_ready = 1'b1; tick(); tick();
      chk("R5 second edge", {31'b0, irq}, 32'h1);
      wr(8'h00, 32'h0);
      tick();
      chk("R6 enable off", {31'b0, irq}, 32'h0);
      wr(8'h00, 32'h4000_0000);
      tick();
      chk("R6 pending kept", {31'b0, irq}, 32'h1);
      rd(8'h08, d);
      aux_msg_ready = 1'b0;
      wr(8'h00, 32'h0);
      tick();
      chk("R6 clean", {31'b0, irq}, 32'h0);

      // R7 hot-plug cause
      wr(8'h00, 32'h8000_0000);
      hpd_event = 2'b10;
      tick();
      hpd_event = 2'b00;
      chk("R9 hpd lag", {31'b0, irq}, 32'h0);
      tick();
      chk("R7 hpd irq", {31'b0, irq}, 32'h1);
      rd(8'h04, d);
      chk("R8 status code", d, 32'h0000_0002);
      tick();
      chk("R8 read clears irq", {31'b0, irq}, 32'h0);
      rd(8'h04, d);
      chk("R8 code cleared", d, 32'h0);
      // R8 new event in same cycle as status read
      hpd_event = 2'b01;
      rd(8'h04, d);
      hpd_event = 2'b00;
      chk("R8 old code returned", d, 32'h0);
      rd(8'h04, d);
      chk("R8 new event wins", d, 32'h0000_0001);
      // R7 masked by enable, code stays latched
      wr(8'h00, 32'h0);
      hpd_event = 2'b11; tick(); hpd_event = 2'b00;
      tick(); tick();
      chk("R7 masked", {31'b0, irq}, 32'h0);
      rd(8'h04, d);
      chk("R7 latched while masked", d, 32'h0000_0003);

      // R1 reset in mid-run
      wr(8'h00, 32'h0280_0087);
      rst_n = 1'b0; tick(); rst_n = 1'b1;
      rd(8'h00, d);
      chk("R1 re-reset", d, 32'h0);
      chk("R4 zero after reset", {31'b0, lanes_zero}, 32'h1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule